// File: doc/BRIEF.md
# Parallel Instruction Boundary Finder

This block takes a fetch group of eight 32-bit code words each clock and reports, within the same cycle, which words begin an instruction. An instruction occupies one, two or three whole words, and its size is fixed by a two-bit field near the top of its first word. The whole window is resolved at once from the size fields, without stepping through it over several cycles. The block reports a start mask, the size of each instruction that starts in the window, and how many words of the last instruction spill past the end of the window.

The spill count is held in a register and is applied to the next accepted group, so an instruction that straddles two groups is handled correctly. A flush input discards the current group and clears the held spill. A redirect input, used when fetch jumps to a new target, ignores the held spill and names the word where decoding begins. The input stream carries `in_valid` only. The block has no ready signal and cannot apply back-pressure. Every group presented with `in_valid` high is consumed in that cycle, and the downstream side must accept every cycle in which `out_valid` is high.

Top module: `ibf_boundary_finder`

## Requirements
- R1: The size of an instruction is read from bits [31:30] of its first word. The values 00 and 01 mean 1 word, 10 means 2 words and 11 means 3 words. For every start word i, `start_len[2i+1:2i]` reports that size as 1, 2 or 3.
- R2: With no held spill and no redirect, word 0 of a valid group is a start. A start at word i with size L makes word i+L a start when i+L < 8. The words between the two starts are not starts.
- R3: Bits [31:30] of a word that is not a start have no effect on any output. `start_len` is 0 for every word whose `start_mask` bit is 0.
- R4: A held spill of c (1 or 2) marks words 0 to c-1 of the next valid group as continuation words rather than starts, and word c becomes the first start.
- R5: `carry_out` is the number of words of the window's last instruction that lie beyond word 7, a value from 0 to 2. At the clock edge this value is stored and then applied to the next valid group. After reset the held spill is 0.
- R6: While `in_valid` is low, `start_mask`, `start_len` and `carry_out` are all zero and the held spill keeps its value.
- R7: When `flush` is high, the current group is discarded: `out_valid` is 0, all outputs are zero, and the held spill becomes 0. Flush takes priority over redirect.
- R8: With `redirect` high and `flush` low, the held spill is ignored. Words below `start_offset` (0 to 7) are not starts, and word `start_offset` is the first start. The spill of a valid redirected group is stored as in R5. A redirect without a valid group clears the held spill.
- R9: `out_valid` is high exactly when `in_valid` is high and `flush` is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Fetch group present this cycle |
| fetch_words | input | 256 | Eight code words; word i at bits [32i+31:32i] |
| flush | input | 1 | Discard the group and clear the held spill |
| redirect | input | 1 | New fetch target: ignore the held spill and use start_offset |
| start_offset | input | 3 | First valid word index on a redirect |
| out_valid | output | 1 | Group decoded this cycle |
| start_mask | output | 8 | Bit i set when word i starts an instruction |
| start_len | output | 16 | Two-bit size for each word, 0 for words that are not starts |
| carry_out | output | 2 | Words of the last instruction beyond word 7 |

## Verification
The assertions check the following on every cycle:
- an idle cycle produces no starts and leaves the held spill unchanged;
- a flush empties the held spill;
- the spill never exceeds two;
- a word that is not a start reports a size of zero;
- held spill words are never marked as starts;
- a redirect always starts at the given offset.

Several properties can only be shown by the bench's scenarios, because they depend on the exact word contents and on the history of earlier groups:
- the full chain of start positions across a window;
- the immunity of continuation words to their size bits;
- the exact spill value passed from one group to the next.

// File: rtl/ibf_pkg.sv
package ibf_pkg;
  localparam int MAX_LEN = 3;
  localparam int LEN_W   = 2;

  typedef logic [LEN_W-1:0] len_t;

  // size field to word count: 00/01 -> 1, 10 -> 2, 11 -> 3
  function automatic len_t size_of(input logic [1:0] fld);
    case (fld)
      2'b10:   size_of = len_t'(2);
      2'b11:   size_of = len_t'(3);
      default: size_of = len_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/ibf_len_decode.sv
module ibf_len_decode
  import ibf_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 32
) (
  input  logic [N_WORDS*WORD_W-1:0] words,
  output len_t                      lens [N_WORDS]
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    assign lens[i] = size_of(words[i*WORD_W+WORD_W-1 -: 2]);
  end
endmodule

// File: rtl/ibf_start_chain.sv
module ibf_start_chain
  import ibf_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int IDX_W   = $clog2(N_WORDS),
  parameter int CARRY_W = $clog2(MAX_LEN)
) (
  input  len_t               lens   [N_WORDS],
  input  logic [IDX_W-1:0]   entry,
  output logic [N_WORDS-1:0] starts,
  output logic [N_WORDS*LEN_W-1:0] start_lens,
  output logic [CARRY_W-1:0] spill
);
  always_comb begin
    logic [N_WORDS-1:0] s;
    s = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      s[i] = (entry == IDX_W'(i));
      for (int d = 1; d <= MAX_LEN; d++) begin
        if (i - d >= 0) begin
          if (s[i-d] && (lens[i-d] == LEN_W'(d))) s[i] = 1'b1;
        end
      end
    end
    starts = s;
  end

  always_comb begin
    spill      = '0;
    start_lens = '0;
    for (int j = 0; j < N_WORDS; j++) begin
      if (starts[j]) begin
        start_lens[j*LEN_W +: LEN_W] = lens[j];
        if (j + int'(lens[j]) > N_WORDS)
          spill = CARRY_W'(j + int'(lens[j]) - N_WORDS);
      end
    end
  end
endmodule

// File: rtl/ibf_carry_reg.sv
module ibf_carry_reg
  import ibf_pkg::*;
#(
  parameter int CARRY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               redirect,
  input  logic               take,
  input  logic [CARRY_W-1:0] spill_in,
  output logic [CARRY_W-1:0] carry_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= '0;
    else if (flush)    carry_q <= '0;
    else if (take)     carry_q <= spill_in;
    else if (redirect) carry_q <= '0;
  end

  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> carry_q == '0);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flush && !redirect) |=> $stable(carry_q));
  p_carry_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(carry_q) < MAX_LEN);
endmodule

// File: rtl/ibf_boundary_finder.sv
module ibf_boundary_finder
  import ibf_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 32,
  localparam int IDX_W   = $clog2(N_WORDS),
  localparam int CARRY_W = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [N_WORDS*WORD_W-1:0] fetch_words,
  input  logic                      flush,
  input  logic                      redirect,
  input  logic [IDX_W-1:0]          start_offset,
  output logic                      out_valid,
  output logic [N_WORDS-1:0]        start_mask,
  output logic [N_WORDS*LEN_W-1:0]  start_len,
  output logic [CARRY_W-1:0]        carry_out
);
  len_t               lens [N_WORDS];
  logic [IDX_W-1:0]   entry;
  logic [N_WORDS-1:0] raw_starts;
  logic [N_WORDS*LEN_W-1:0] raw_lens;
  logic [CARRY_W-1:0] raw_spill;
  logic [CARRY_W-1:0] carry_q;
  logic               take;

  assign take  = in_valid && !flush;
  assign entry = redirect ? start_offset : IDX_W'(carry_q);

  ibf_len_decode #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_dec (
    .words (fetch_words),
    .lens  (lens)
  );

  ibf_start_chain #(.N_WORDS(N_WORDS), .IDX_W(IDX_W), .CARRY_W(CARRY_W)) u_chain (
    .lens       (lens),
    .entry      (entry),
    .starts     (raw_starts),
    .start_lens (raw_lens),
    .spill      (raw_spill)
  );

  ibf_carry_reg #(.CARRY_W(CARRY_W)) u_carry (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .redirect (redirect),
    .take     (take),
    .spill_in (raw_spill),
    .carry_q  (carry_q)
  );

  assign out_valid  = take;
  assign start_mask = take ? raw_starts : '0;
  assign start_len  = take ? raw_lens   : '0;
  assign carry_out  = take ? raw_spill  : '0;

  p_idle_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (start_mask == '0 && carry_out == '0));
  p_cont_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !redirect && carry_q != '0) |-> !start_mask[0]);
  p_redirect_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && redirect) |-> start_mask[start_offset]);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_chk
    p_nonstart_len_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !start_mask[i] |-> start_len[i*LEN_W +: LEN_W] == '0);
  end
endmodule

// File: tb/ibf_boundary_finder_tb.sv
module ibf_boundary_finder_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] fetch_words = '0;
  logic         flush = 1'b0;
  logic         redirect = 1'b0;
  logic [2:0]   start_offset = '0;
  logic         out_valid;
  logic [7:0]   start_mask;
  logic [15:0]  start_len;
  logic [1:0]   carry_out;

  int vectors = 0;
  int fails   = 0;
  int m_carry = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibf_boundary_finder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_words(fetch_words),
    .flush(flush), .redirect(redirect), .start_offset(start_offset),
    .out_valid(out_valid), .start_mask(start_mask), .start_len(start_len),
    .carry_out(carry_out)
  );

  function automatic int fld_len(input logic [1:0] f);
    return (f == 2'b11) ? 3 : (f == 2'b10) ? 2 : 1;
  endfunction

  function automatic void ref_decode(input logic [255:0] w, input int first,
                                     output logic [7:0] m, output logic [15:0] l,
                                     output int cout);
    int pos = first;
    m = '0; l = '0; cout = 0;
    while (pos < 8) begin
      int len = fld_len(w[pos*32+30 +: 2]);
      m[pos] = 1'b1;
      l[pos*2 +: 2] = 2'(len);
      if (pos + len > 8) cout = pos + len - 8;
      pos += len;
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] fill(input logic [1:0] f);
    logic [255:0] w;
    for (int i = 0; i < 8; i++) w[i*32 +: 32] = {f, 30'(i * 7 + 1)};
    return w;
  endfunction

  // drive one cycle at negedge, check, then let the edge update state
  task automatic step(input logic v, input logic [255:0] w, input logic fl,
                      input logic rd, input logic [2:0] off);
    logic [7:0]  em;
    logic [15:0] el;
    int          ec, first;
    string       rq;
    @(negedge clk);
    in_valid = v; fetch_words = w; flush = fl; redirect = rd; start_offset = off;
    first = rd ? int'(off) : m_carry;
    ref_decode(w, first, em, el, ec);
    if (!(v && !fl)) begin em = '0; el = '0; ec = 0; end
    if (fl)            rq = "R7";
    else if (!v)       rq = "R6";
    else if (rd)       rq = "R8";
    else if (m_carry != 0) rq = "R4";
    else               rq = "R2";
    #(CLK_PERIOD/4);
    check(rq, 32'(start_mask), 32'(em));
    check("R1_R3", 32'(start_len), 32'(el));
    check("R5", 32'(carry_out), 32'(ec));
    check("R9", 32'(out_valid), 32'(v && !fl));
    if (fl)      m_carry = 0;
    else if (v)  m_carry = ec;
    else if (rd) m_carry = 0;
  endtask

  initial begin
    logic [255:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R6 reset", 32'(start_mask), 32'h0);
    check("R9 reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;

    // R5: held spill is 0 after reset; all one-word instructions
    step(1, fill(2'b00), 0, 0, 0);
    step(1, fill(2'b01), 0, 0, 0);
    // all three-word: starts 0,3,6, spill 1 (R2, R5)
    step(1, fill(2'b11), 0, 0, 0);
    // spill 1 applied (R4), then idle must hold it (R6)
    step(0, fill(2'b11), 0, 0, 0);
    step(1, fill(2'b10), 0, 0, 0);
    // build spill 2: redirect to word 7 with a three-word instruction (R8)
    w = fill(2'b00); w[7*32+30 +: 2] = 2'b11;
    step(1, w, 0, 1, 3'd7);
    // spill 2: words 0,1 continuations whose size bits must not matter (R4, R3)
    w = fill(2'b00); w[30 +: 2] = 2'b11; w[32+30 +: 2] = 2'b10;
    step(1, w, 0, 0, 0);
    // flush clears held spill (R7)
    step(1, fill(2'b11), 0, 0, 0);
    step(1, fill(2'b11), 1, 1, 3'd5);
    step(1, fill(2'b00), 0, 0, 0);
    // redirect without a group clears spill (R8)
    step(1, fill(2'b11), 0, 0, 0);
    step(0, fill(2'b00), 0, 1, 3'd2);
    step(1, fill(2'b00), 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [255:0] rw;
      for (int k = 0; k < 8; k++) rw[k*32 +: 32] = $urandom;
      step(($urandom % 8) != 0, rw, ($urandom % 16) == 0,
           ($urandom % 6) == 0, 3'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule